// File: doc/BRIEF.md
# Carry-Pipelined Binary Counter with Skew Correction

This block is a free-running binary up-counter for fabrics that have no fast carry chain. Each bit is a toggle flop. A stage hands its carry to the next stage through a one-bit register, so every path between flops is one two-way selector, whatever the width. The carry therefore advances one stage per enabled clock. Raw bit k lags the true count by k enabled clocks, and the raw word is not a linear binary value.

A correction network rebuilds the true count from the raw word. It works from bit 1 upward. When the already-corrected bits below position k, read as a number, are smaller than k, bit k is inverted. That low value being under k means the low field wrapped during the k clocks that bit k lags. The corrected count can leave the block directly or through one output register, chosen by a parameter.

The enable stalls the whole pipeline: stage flops and carry registers. The lag of every bit is then counted in enabled clocks, and the correction stays exact through any enable pattern. Reset loads the skewed image of count zero, so the corrected output reads zero from the first cycle.

Top module: `pcc_counter`

## Requirements
- R1: Synchronous reset sets the corrected count to 0. Raw bit k takes bit k of (2^N − k) mod 2^N, the two's complement of k. The carry toward stage 1 starts pending.
- R2: Raw bit 0 inverts on every clock where the enable is high.
- R3: Each stage k ≥ 1 inverts only on an enabled clock where its incoming carry pulse is high. That pulse is registered on the enabled clock where stage k−1 falls from 1 to 0. It stays high for exactly one enabled clock.
- R4: With n the number of enabled clocks since reset, raw bit k equals bit k of (n − k) mod 2^N.
- R5: With the output register off, the corrected count equals n mod 2^N in the same cycle. This includes the wrap from all ones to zero.
- R6: While the enable is low, the raw word, the carry registers and the corrected count keep their values.
- R7: With the output register on, the corrected count shows the value of the cycle before, and reads 0 after reset.
- R8: Correction runs for k = 1 to N−1 in ascending order. Bit k is inverted when the low k bits of the partly corrected word, as an unsigned number, are below k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable; low stalls the whole pipeline |
| raw_o | output | W | Skewed raw word taken straight from the stage flops |
| count_o | output | W | Corrected binary count |

## Verification
The assertions assume that the enable and reset are clean, synchronous levels. They also assume that reset is held for at least one clock before counting starts, so every history they use begins in the preloaded state. The per-stage pulse and gating properties take the pipeline as the only source of carries, which holds because nothing outside can load a stage. The stimulus drives the enable and reset only at the falling edge. It holds reset for several clocks at the start and once in mid-run. It mixes runs of full enable, alternating enable, random enable and long stalls, so every stage sees carries in flight while the pipeline is frozen.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam int MAXW = 64;
  typedef logic [MAXW-1:0] word_t;

  // Bit k of the raw word after n enabled clocks: bit k of (n - k).
  function automatic logic raw_bit_at(input word_t n, input int k);
    return 1'(((n - word_t'(k)) >> k) & word_t'(1));
  endfunction

  // Carry toward stage k is pending after n enabled clocks when the next
  // clock moves stage k, i.e. (n + 1 - k) is a multiple of 2^k.
  function automatic logic carry_due(input word_t n, input int k);
    return (k > 0) &&
           (((n + word_t'(1) - word_t'(k)) & ((word_t'(1) << k) - word_t'(1))) == '0);
  endfunction

endpackage

// File: rtl/pcc_stage.sv
module pcc_stage #(
  parameter int W   = 32,
  parameter int IDX = 0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic carry_i,
  output logic q_o
);
  // Reset value is the skewed image of count zero (R1).
  localparam logic RST_VAL = pcc_pkg::raw_bit_at(pcc_pkg::word_t'(0), IDX);
  localparam int   W_USED  = W;

  logic q;

  // One selector level: hold or invert (R2, R3, R6).
  always_ff @(posedge clk_i) begin
    if (rst_i)                q <= RST_VAL;
    else if (en_i && carry_i) q <= ~q;
  end

  assign q_o = q;
endmodule

// File: rtl/pcc_carry.sv
module pcc_carry #(
  parameter int IDX = 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic carry_i,
  input  logic bit_i,
  output logic pulse_o
);
  localparam logic RST_VAL = pcc_pkg::carry_due(pcc_pkg::word_t'(0), IDX);

  logic pulse;

  // Stage IDX-1 falls 1->0 when it is carried into while at 1 (R3).
  always_ff @(posedge clk_i) begin
    if (rst_i)     pulse <= RST_VAL;
    else if (en_i) pulse <= carry_i & bit_i;
  end

  assign pulse_o = pulse;
endmodule

// File: rtl/pcc_fix.sv
module pcc_fix #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cnt_o
);
  typedef logic [W-1:0] cw_t;

  function automatic cw_t low_mask(input int k);
    cw_t m;
    m = '0;
    for (int j = 0; j < W; j++) if (j < k) m[j] = 1'b1;
    return m;
  endfunction

  // R8: ascending pass, each step sees the word already corrected below it.
  function automatic cw_t fix_word(input cw_t raw);
    cw_t v;
    v = raw;
    for (int k = 1; k < W; k++) begin
      if ((v & low_mask(k)) < cw_t'(k)) v[k] = ~v[k];
    end
    return v;
  endfunction

  cw_t fixed_w;
  assign fixed_w = fix_word(raw_i);

  generate
    if (OUT_REG) begin : g_reg
      cw_t cnt_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= fixed_w;
      end
      assign cnt_o = cnt_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_i;
      assign cnt_o = fixed_w;
    end
  endgenerate
endmodule

// File: rtl/pcc_counter.sv
module pcc_counter #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] count_o
);
  // carry_w[k] is the pulse entering stage k; stage 0 is always carried into.
  logic [W-1:0] carry_w;
  logic [W-1:0] raw_w;

  assign carry_w[0] = 1'b1;

  generate
    for (genvar k = 0; k < W; k++) begin : g_bit
      pcc_stage #(.W(W), .IDX(k)) stage_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .carry_i(carry_w[k]),
        .q_o    (raw_w[k])
      );
      if (k > 0) begin : g_cy
        pcc_carry #(.IDX(k)) carry_i (
          .clk_i  (clk_i),
          .rst_i  (rst_i),
          .en_i   (en_i),
          .carry_i(carry_w[k-1]),
          .bit_i  (raw_w[k-1]),
          .pulse_o(carry_w[k])
        );
      end
    end
  endgenerate

  pcc_fix #(.W(W), .OUT_REG(OUT_REG)) fix_i (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .raw_i(raw_w),
    .cnt_o(count_o)
  );

  assign raw_o = raw_w;
endmodule

// File: rtl/pcc_counter_chk.sv
module pcc_counter_chk #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b0
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         en_i,
  input logic [W-1:0] raw_o,
  input logic [W-1:0] count_o,
  input logic [W-1:0] carry_w
);

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    rst_i |=> (count_o == '0));

  assert_bit0_toggle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (raw_o[0] != $past(raw_o[0])));

  generate
    for (genvar k = 0; k < W; k++) begin : g_stage
      assert_gate_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(en_i && carry_w[k]) |=> $stable(raw_o[k]));
      if (k > 0) begin : g_pulse
        assert_pulse_one_R3: assert property (@(posedge clk_i) disable iff (rst_i)
          (en_i && carry_w[k]) |=> !carry_w[k]);
        assert_carry_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
          !en_i |=> $stable(carry_w[k]));
      end
    end
    if (!OUT_REG) begin : g_comb_chk
      assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(count_o));
      assert_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (count_o == W'($past(count_o) + 1'b1)));
    end
  endgenerate

endmodule

bind pcc_counter pcc_counter_chk #(.W(W), .OUT_REG(OUT_REG)) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .en_i   (en_i),
  .raw_o  (raw_o),
  .count_o(count_o),
  .carry_w(carry_w)
);

// File: tb/pcc_counter_tb.sv
`timescale 1ns/1ps
module pcc_counter_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;

  always #4 clk = ~clk;

  logic [5:0]  raw6,  cnt6;
  logic [31:0] raw32, cnt32;
  logic [5:0]  rawr,  cntr;

  pcc_counter #(.W(6), .OUT_REG(1'b0)) dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .raw_o(raw6), .count_o(cnt6));
  pcc_counter #(.W(32), .OUT_REG(1'b0)) dut_wide_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .raw_o(raw32), .count_o(cnt32));
  pcc_counter #(.W(6), .OUT_REG(1'b1)) dut_reg_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .raw_o(rawr), .count_o(cntr));

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  longint unsigned n      = 0;
  longint unsigned n_prev = 0;
  logic [5:0]  old_raw6;
  logic [5:0]  old_cnt6;

  // Raw image after n enabled clocks: bit k of (n - k).
  function automatic logic [63:0] exp_raw(input longint unsigned cnt, input int w);
    logic [63:0] r;
    longint unsigned d;
    r = '0;
    for (int k = 0; k < w; k++) begin
      d = cnt - longint'(k);
      r[k] = d[k];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h (n=%0d)", req, act, expv, n);
    end
  endtask

  task automatic check_reset_state();
    check("R1 count after reset", 64'(cnt6), 64'd0);
    check("R1 raw after reset", 64'(raw6), exp_raw(0, 6));
    check("R1 wide raw after reset", 64'(raw32), exp_raw(0, 32));
    check("R1 wide count after reset", 64'(cnt32), 64'd0);
    check("R7 registered count after reset", 64'(cntr), 64'd0);
    old_raw6 = raw6;
    old_cnt6 = cnt6;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    repeat (3) @(posedge clk);
    n = 0;
    n_prev = 0;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state();
  endtask

  task automatic step(input logic e);
    logic [63:0] mask;
    en = e;
    @(posedge clk);
    n_prev = n;
    if (e) n = n + 1;
    @(negedge clk);
    check("R5 R8 corrected count", 64'(cnt6), n & 64'h3F);
    check("R4 raw word", 64'(raw6), exp_raw(n, 6));
    check("R5 wide corrected count", 64'(cnt32), n & 64'hFFFF_FFFF);
    check("R4 wide raw word", 64'(raw32), exp_raw(n, 32));
    check("R7 registered count lags", 64'(cntr), n_prev & 64'h3F);
    mask = exp_raw(n, 6) ^ exp_raw(n_prev, 6);
    check("R3 stages that moved", 64'(raw6 ^ old_raw6), mask);
    if (e) begin
      check("R2 bit0 toggled", 64'(raw6[0] ^ old_raw6[0]), 64'd1);
    end else begin
      check("R6 raw frozen", 64'(raw6), 64'(old_raw6));
      check("R6 count frozen", 64'(cnt6), 64'(old_cnt6));
    end
    old_raw6 = raw6;
    old_cnt6 = cnt6;
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 150; i++) step(1'b1);           // several wraps of 6 bits
    for (int i = 0; i < 100; i++) step(1'(i % 2));      // alternating
    for (int i = 0; i < 300; i++) step(($urandom_range(0, 3) != 0) ? 1'b1 : 1'b0);
    for (int i = 0; i < 20; i++)  step(1'b0);           // long stall
    for (int i = 0; i < 37; i++)  step(1'b1);
    do_reset();                                          // mid-run reset
    for (int i = 0; i < 80; i++)  step(1'b1);
    for (int i = 0; i < 200; i++) step(($urandom_range(0, 1) != 0) ? 1'b1 : 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule